// File: doc/BRIEF.md
# In-Order Completion Buffer

This block tracks instructions between issue and retirement in a core whose execution units may finish out of program order. Issue logic allocates one slot per instruction and stamps it with the instruction's tag. Execution units report finished work by tag, not by slot index, and the buffer marks every live slot that holds that tag as done. Slots leave the buffer only from the oldest end and only in program order. Up to two slots can leave in one cycle.

The buffer is a circular queue of six slots, with an oldest pointer and an allocation pointer. Issue logic reads the free-slot count and must stall while it is zero. The allocate port is also guarded inside the buffer. A completion report whose tag matches no live slot changes nothing, and it sets a sticky flag that verification can watch.

Top module: `cbuf_top`

## Requirements
- R1: A synchronous active-high reset empties every slot, sets `free_cnt` to the depth (6), sets `ret_vld` to 0 and clears `miss_err`. The next cycle after reset releases shows this state.
- R2: When `free_cnt` is nonzero, `alloc_vld` at a clock edge fills the next slot with `alloc_tag`, and `free_cnt` falls by one after that edge. When `free_cnt` is zero, `alloc_vld` is ignored, even in a cycle where a slot retires. A tag offered that way never retires.
- R3: A report on port p (`cmpl_vld[p]` high, tag in `cmpl_tag[p*TAG_W +: TAG_W]`) marks done every live slot holding that tag. If that slot is the oldest, it appears on retire lane 0 in the cycle after the report.
- R4: A done slot never retires while an older slot is still waiting. Retirement is strictly in allocation order.
- R5: When the two oldest slots are both done, both retire in the same cycle. Lane 0 (`ret_tag[TAG_W-1:0]`) carries the older tag and lane 1 carries the younger. `ret_vld[1]` is never high without `ret_vld[0]`.
- R6: No more than two slots retire in one cycle. A third done slot waits for the next cycle.
- R7: Retirement in a cycle depends only on the done flags held at the start of that cycle. A report for the oldest slot arriving in cycle c does not make `ret_vld[0]` high in cycle c.
- R8: A report whose tag matches no live slot leaves all slots unchanged and sets `miss_err`. `miss_err` stays high until reset.
- R9: An allocation and retirements in the same cycle are both carried out. `free_cnt` changes by their net effect.
- R10: The pointers wrap modulo the depth, and program order holds across the wrap.
- R11: Reports on several ports in the same cycle each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_vld | input | 1 | Request to allocate a slot |
| alloc_tag | input | TAG_W | Tag of the instruction being allocated |
| cmpl_vld | input | NCMP | Completion report valid, one bit per port |
| cmpl_tag | input | NCMP*TAG_W | Completion tags, port p at bits p*TAG_W upward |
| ret_vld | output | RET_MAX | Retire lane valid; lane 0 is the oldest |
| ret_tag | output | RET_MAX*TAG_W | Retired tags, lane k at bits k*TAG_W upward, zero when the lane is idle |
| free_cnt | output | $clog2(DEPTH+1) | Number of empty slots |
| miss_err | output | 1 | Sticky flag for a report that matched no live slot |

## Verification
The hardest condition to reach is a full buffer that is retiring one slot while a new allocation is offered. The offer must be refused, and the refused tag must never show up later. The stimulus fills all six slots after the pointers have already wrapped once. It then finishes the oldest slot and offers two extra tags, one while the buffer is full and idle and one in the cycle it retires. Finally it drains the buffer two slots at a time, so that any slot taken by mistake would appear on a retire lane or in the final free count.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
   // advance a circular index by n steps within a ring of the given size
   function automatic int ring_step(int idx, int n, int size);
      return (idx + n) % size;
   endfunction
endpackage

// File: rtl/cbuf_tag_match.sv
module cbuf_tag_match #(
   parameter int DEPTH = 6,
   parameter int TAG_W = 6,
   parameter int NCMP  = 3
) (
   input  logic [DEPTH-1:0]             live,
   input  logic [DEPTH-1:0][TAG_W-1:0]  slot_tag,
   input  logic [NCMP-1:0]              rpt_vld,
   input  logic [NCMP*TAG_W-1:0]        rpt_tag,
   output logic [DEPTH-1:0]             mark_done,
   output logic                         any_miss
);
   logic [NCMP-1:0][DEPTH-1:0] hit;
   logic [NCMP-1:0]            port_miss;

   for (genvar p = 0; p < NCMP; p++) begin : g_port
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         assign hit[p][s] = rpt_vld[p] & live[s] &
                            (slot_tag[s] == rpt_tag[p*TAG_W +: TAG_W]);
      end
      assign port_miss[p] = rpt_vld[p] & ~(|hit[p]);
   end

   always_comb begin
      mark_done = '0;
      for (int p = 0; p < NCMP; p++) begin
         mark_done = mark_done | hit[p];
      end
   end

   assign any_miss = |port_miss;
endmodule

// File: rtl/cbuf_retire_sel.sv
module cbuf_retire_sel #(
   parameter int DEPTH   = 6,
   parameter int RET_MAX = 2,
   parameter int PTR_W   = 3
) (
   input  logic [PTR_W-1:0]                 head,
   input  logic [DEPTH-1:0]                 live,
   input  logic [DEPTH-1:0]                 done,
   output logic [RET_MAX-1:0]               take,
   output logic [RET_MAX-1:0][PTR_W-1:0]    lane_slot,
   output logic [DEPTH-1:0]                 drop
);
   always_comb begin
      logic run;
      int   idx;
      run  = 1'b1;
      drop = '0;
      for (int k = 0; k < RET_MAX; k++) begin
         idx          = cbuf_pkg::ring_step(int'(head), k, DEPTH);
         lane_slot[k] = PTR_W'(idx);
         run          = run & live[idx] & done[idx];
         take[k]      = run;
         if (run) drop[idx] = 1'b1;
      end
   end
endmodule

// File: rtl/cbuf_top.sv
module cbuf_top #(
   parameter int DEPTH      = 6,
   parameter int TAG_W      = 6,
   parameter int NCMP       = 3,
   parameter int RET_MAX    = 2,
   parameter bit TRACK_MISS = 1'b1,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     alloc_vld,
   input  logic [TAG_W-1:0]         alloc_tag,
   input  logic [NCMP-1:0]          cmpl_vld,
   input  logic [NCMP*TAG_W-1:0]    cmpl_tag,
   output logic [RET_MAX-1:0]       ret_vld,
   output logic [RET_MAX*TAG_W-1:0] ret_tag,
   output logic [CNT_W-1:0]         free_cnt,
   output logic                     miss_err
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2)        begin : g_chk_depth $error("cbuf_top: DEPTH must be at least 2"); end
   if (TAG_W < 1)        begin : g_chk_tag   $error("cbuf_top: TAG_W must be positive"); end
   if (NCMP < 1)         begin : g_chk_ncmp  $error("cbuf_top: NCMP must be positive"); end
   if (RET_MAX < 1 || RET_MAX > DEPTH) begin : g_chk_ret
      $error("cbuf_top: RET_MAX must lie in 1..DEPTH");
   end

   logic [DEPTH-1:0]            live_q, live_d;
   logic [DEPTH-1:0]            done_q, done_d;
   logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
   logic [PTR_W-1:0]            head_q, head_d;
   logic [PTR_W-1:0]            tail_q, tail_d;
   logic [CNT_W-1:0]            used_q, used_d;
   logic                        err_q, err_d;

   logic [DEPTH-1:0]            mark_done;
   logic                        any_miss;
   logic [RET_MAX-1:0]          take;
   logic [RET_MAX-1:0][PTR_W-1:0] lane_slot;
   logic [DEPTH-1:0]            drop;
   logic                        alloc_ok;
   logic [CNT_W-1:0]            ret_num;

   cbuf_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NCMP(NCMP)) u_match (
      .live      (live_q),
      .slot_tag  (tag_q),
      .rpt_vld   (cmpl_vld),
      .rpt_tag   (cmpl_tag),
      .mark_done (mark_done),
      .any_miss  (any_miss)
   );

   cbuf_retire_sel #(.DEPTH(DEPTH), .RET_MAX(RET_MAX), .PTR_W(PTR_W)) u_ret (
      .head      (head_q),
      .live      (live_q),
      .done      (done_q),
      .take      (take),
      .lane_slot (lane_slot),
      .drop      (drop)
   );

   // retire lanes: oldest on lane 0, tag forced to zero when idle
   for (genvar k = 0; k < RET_MAX; k++) begin : g_lane
      assign ret_vld[k]                   = take[k];
      assign ret_tag[k*TAG_W +: TAG_W]    = take[k] ? tag_q[lane_slot[k]] : '0;
   end

   always_comb begin
      ret_num = '0;
      for (int k = 0; k < RET_MAX; k++) begin
         ret_num = ret_num + CNT_W'(take[k]);
      end
   end

   assign alloc_ok = alloc_vld && (used_q != CNT_W'(DEPTH));
   assign free_cnt = CNT_W'(DEPTH) - used_q;

   always_comb begin
      live_d = live_q;
      done_d = done_q;
      tag_d  = tag_q;
      for (int s = 0; s < DEPTH; s++) begin
         if (drop[s]) begin
            live_d[s] = 1'b0;
            done_d[s] = 1'b0;
         end else if (mark_done[s]) begin
            done_d[s] = 1'b1;
         end
      end
      // the tail slot is empty whenever alloc_ok, so it cannot be dropped or marked
      if (alloc_ok) begin
         live_d[tail_q] = 1'b1;
         done_d[tail_q] = 1'b0;
         tag_d[tail_q]  = alloc_tag;
      end
      head_d = PTR_W'(cbuf_pkg::ring_step(int'(head_q), int'(ret_num), DEPTH));
      tail_d = alloc_ok ? PTR_W'(cbuf_pkg::ring_step(int'(tail_q), 1, DEPTH)) : tail_q;
      used_d = used_q + CNT_W'(alloc_ok) - ret_num;
   end

   if (TRACK_MISS) begin : g_miss_on
      assign err_d = err_q | any_miss;
   end else begin : g_miss_off
      assign err_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q <= '0;
         done_q <= '0;
         tag_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         used_q <= '0;
         err_q  <= 1'b0;
      end else begin
         live_q <= live_d;
         done_q <= done_d;
         tag_q  <= tag_d;
         head_q <= head_d;
         tail_q <= tail_d;
         used_q <= used_d;
         err_q  <= err_d;
      end
   end

   assign miss_err = err_q;
endmodule

// File: rtl/cbuf_chk.sv
module cbuf_chk #(
   parameter int DEPTH      = 6,
   parameter int TAG_W      = 6,
   parameter int NCMP       = 3,
   parameter int RET_MAX    = 2,
   parameter bit TRACK_MISS = 1'b1,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     alloc_vld,
   input logic [TAG_W-1:0]         alloc_tag,
   input logic [NCMP-1:0]          cmpl_vld,
   input logic [NCMP*TAG_W-1:0]    cmpl_tag,
   input logic [RET_MAX-1:0]       ret_vld,
   input logic [RET_MAX*TAG_W-1:0] ret_tag,
   input logic [CNT_W-1:0]         free_cnt,
   input logic                     miss_err
);
   assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (int'(free_cnt) == DEPTH && ret_vld == '0 && !miss_err));

   assert_free_bound_R2: assert property (@(posedge clk) disable iff (rst)
      int'(free_cnt) <= DEPTH);

   assert_full_refuse_R2: assert property (@(posedge clk) disable iff (rst)
      (free_cnt == '0 && alloc_vld) |=> (int'(free_cnt) == int'($past($countones(ret_vld)))));

   assert_lanes_in_order_R5: assert property (@(posedge clk) disable iff (rst)
      ((ret_vld & (ret_vld + 1'b1)) == '0));

   assert_net_count_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (int'(free_cnt) == int'($past(free_cnt))
                 - (($past(alloc_vld) && $past(free_cnt) != '0) ? 1 : 0)
                 + int'($past($countones(ret_vld)))));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      miss_err |=> miss_err);

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(miss_err) |-> $past(cmpl_vld != '0));
endmodule

bind cbuf_top cbuf_chk #(
   .DEPTH(DEPTH), .TAG_W(TAG_W), .NCMP(NCMP), .RET_MAX(RET_MAX), .TRACK_MISS(TRACK_MISS)
) u_chk (.*);

// File: tb/sim_cbuf_top.sv
module sim_cbuf_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        alloc_vld = 1'b0;
   logic [5:0]  alloc_tag = '0;
   logic [2:0]  cmpl_vld  = '0;
   logic [17:0] cmpl_tag  = '0;
   logic [1:0]  ret_vld;
   logic [11:0] ret_tag;
   logic [2:0]  free_cnt;
   logic        miss_err;

   int applied = 0;
   int bad     = 0;
   bit ended   = 0;

   always #5 clk = ~clk;

   cbuf_top u0 (
      .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
      .cmpl_vld(cmpl_vld), .cmpl_tag(cmpl_tag), .ret_vld(ret_vld),
      .ret_tag(ret_tag), .free_cnt(free_cnt), .miss_err(miss_err)
   );

   typedef struct packed {
      logic       av;
      logic [5:0] at;
      logic [2:0] cv;
      logic [5:0] ct0, ct1, ct2;
      logic [1:0] erv;
      logic [5:0] ert0, ert1;
      logic [2:0] efree;
      logic       eerr;
   } vec_t;

   localparam int NV = 29;
   // each row: inputs driven this cycle, outputs expected in this same cycle
   localparam vec_t TBL [NV] = '{
      '{1,10,3'b000, 0, 0, 0, 2'b00, 0, 0,6,0},   // 0  R1 R2
      '{1,11,3'b000, 0, 0, 0, 2'b00, 0, 0,5,0},   // 1  R2
      '{1,12,3'b000, 0, 0, 0, 2'b00, 0, 0,4,0},   // 2  R2
      '{1,13,3'b001,11, 0, 0, 2'b00, 0, 0,3,0},   // 3  R4 younger done
      '{0, 0,3'b001,10, 0, 0, 2'b00, 0, 0,2,0},   // 4  R4 R7 head report not seen yet
      '{0, 0,3'b000, 0, 0, 0, 2'b11,10,11,2,0},   // 5  R3 R5
      '{1,14,3'b110, 0,12,13, 2'b00, 0, 0,4,0},   // 6  R11
      '{1,15,3'b001,14, 0, 0, 2'b11,12,13,3,0},   // 7  R9 alloc with two retiring
      '{0, 0,3'b000, 0, 0, 0, 2'b01,14, 0,4,0},   // 8  R9 net count
      '{1,16,3'b000, 0, 0, 0, 2'b00, 0, 0,5,0},   // 9  R10 tail wraps
      '{1,17,3'b000, 0, 0, 0, 2'b00, 0, 0,4,0},   // 10 R10
      '{0, 0,3'b111,15,16,17, 2'b00, 0, 0,3,0},   // 11 R11
      '{0, 0,3'b000, 0, 0, 0, 2'b11,15,16,3,0},   // 12 R6 R10
      '{0, 0,3'b000, 0, 0, 0, 2'b01,17, 0,5,0},   // 13 R6
      '{0, 0,3'b001,40, 0, 0, 2'b00, 0, 0,6,0},   // 14 R8 unmatched tag
      '{1,20,3'b000, 0, 0, 0, 2'b00, 0, 0,6,1},   // 15 R8
      '{1,21,3'b000, 0, 0, 0, 2'b00, 0, 0,5,1},   // 16 R2
      '{1,22,3'b000, 0, 0, 0, 2'b00, 0, 0,4,1},   // 17 R2
      '{1,23,3'b000, 0, 0, 0, 2'b00, 0, 0,3,1},   // 18 R2
      '{1,24,3'b000, 0, 0, 0, 2'b00, 0, 0,2,1},   // 19 R2
      '{1,25,3'b000, 0, 0, 0, 2'b00, 0, 0,1,1},   // 20 R2
      '{1,26,3'b000, 0, 0, 0, 2'b00, 0, 0,0,1},   // 21 R2 full, refused
      '{0, 0,3'b001,20, 0, 0, 2'b00, 0, 0,0,1},   // 22 R3
      '{1,27,3'b000, 0, 0, 0, 2'b01,20, 0,0,1},   // 23 R2 full while retiring, refused
      '{0, 0,3'b111,21,22,23, 2'b00, 0, 0,1,1},   // 24 R11
      '{0, 0,3'b011,24,25, 0, 2'b11,21,22,1,1},   // 25 R5
      '{0, 0,3'b000, 0, 0, 0, 2'b11,23,24,3,1},   // 26 R6
      '{0, 0,3'b000, 0, 0, 0, 2'b01,25, 0,5,1},   // 27 R10
      '{0, 0,3'b000, 0, 0, 0, 2'b00, 0, 0,6,1}    // 28 R2 refused tags never appear
   };
   localparam int REQ [NV] = '{1,2,2,4,7,5,11,9,9,10,10,11,6,6,8,8,2,2,2,2,2,2,3,2,11,5,6,10,2};

   task automatic check_out(input int req, input logic [1:0] erv, input logic [5:0] e0,
                            input logic [5:0] e1, input logic [2:0] efree, input logic eerr);
      logic [1:0] gv = ret_vld;
      logic [5:0] g0 = ret_tag[5:0];
      logic [5:0] g1 = ret_tag[11:6];
      applied++;
      if (gv !== erv || (erv[0] && g0 !== e0) || (erv[1] && g1 !== e1) ||
          free_cnt !== efree || miss_err !== eerr) begin
         bad++;
         $display("FAIL R%0d: got vld=%b tag0=%0d tag1=%0d free=%0d err=%b, expected vld=%b tag0=%0d tag1=%0d free=%0d err=%b",
                  req, gv, g0, g1, free_cnt, miss_err, erv, e0, e1, efree, eerr);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         alloc_vld = TBL[i].av;
         alloc_tag = TBL[i].at;
         cmpl_vld  = TBL[i].cv;
         cmpl_tag  = {TBL[i].ct2, TBL[i].ct1, TBL[i].ct0};
         #1;
         check_out(REQ[i], TBL[i].erv, TBL[i].ert0, TBL[i].ert1, TBL[i].efree, TBL[i].eerr);
         @(negedge clk);
      end

      // directed: reset in the middle of activity clears slots and the flag (R1)
      alloc_vld = 1'b1; alloc_tag = 6'd30; cmpl_vld = '0;
      @(negedge clk);
      alloc_tag = 6'd31;
      @(negedge clk);
      alloc_vld = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check_out(1, 2'b00, 0, 0, 3'd6, 1'b0);   // R1 reset state
      // a report for a tag held before reset now matches nothing (R1, R8)
      cmpl_vld = 3'b001; cmpl_tag = {12'd0, 6'd30};
      @(negedge clk);
      cmpl_vld = '0;
      #1;
      check_out(8, 2'b00, 0, 0, 3'd6, 1'b1);   // R8 flag raised, nothing retires
      @(negedge clk);
      finish_run();
   end
endmodule